// File: doc/BRIEF.md
# Nibble-Coded Register Command Decoder

This block takes a byte stream from a host link and turns it into accesses to a small 8-bit register file. The upper four bits of every incoming byte select an operation; the lower four bits carry a payload nibble. A register address is built from two nibble commands. Each data byte travels as a low-nibble command followed by a high-nibble command, and the high-nibble command also performs the write. A read command returns the addressed register as one response byte. An optional flag on the read moves the address on by one afterwards, so successive registers can be fetched in a single burst.

Response bytes wait in a small output FIFO, in the same order as the reads that produced them. While that FIFO is full the decoder holds `cmd_ready` low and accepts no command. The register file holds a fixed identification value, a scratch register for link testing, and a mode register that drives an output port. It also exposes, read-only, two 24-bit capture positions that the surrounding logic supplies.

Top module: `regcmd_decoder`

## Requirements
- R1: After reset `cmd_ready` is 1, `rsp_valid` is 0, `mode_o` is 0x00 and the register address is 0x00.
- R2: Command byte 0x0n sets address bits [3:0] to n and command byte 0x1n sets address bits [7:4] to n. In both cases the other nibble of the address keeps its value.
- R3: Command byte 0x2n stores n as a pending low nibble. Command byte 0x3m writes the byte {m, pending nibble} to the addressed register. A write leaves the address unchanged, so several nibble pairs in a row write the same register, and the last pair wins.
- R4: Command byte 0x40 queues exactly one response byte holding the addressed register's contents and leaves the address unchanged.
- R5: Command byte 0xC0 behaves as 0x40 and then adds one to the address, wrapping from 0xFF to 0x00. The payload nibble of either read command is ignored.
- R6: Address 0x00 always reads 0xA6, and writes to it have no effect.
- R7: Address 0x01 reads back the last byte written to it (0x55 and 0xAA both survive).
- R8: Address 0x02 is a read/write mode register whose value drives `mode_o` from the clock edge that accepts the write.
- R9: Addresses 0x03 to 0x08 read, in this order, bytes 0, 1 and 2 of `trig_pos` and then bytes 0, 1 and 2 of `stop_pos`, least significant byte first. They are read-only. Every address above 0x08 reads 0x00 and ignores writes.
- R10: Response bytes leave in the order of their read commands. The queue holds RSP_DEPTH (default 4) bytes. While it is full `cmd_ready` is 0 and no command is consumed.
- R11: Command bytes whose upper nibble is 0x5 to 0xB or 0xD to 0xF are consumed with no response and no change to any register, address or pending nibble.
- R12: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_byte` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_byte | input | 8 | Command: operation in [7:4], payload nibble in [3:0] |
| cmd_ready | output | 1 | Decoder accepts a command this cycle |
| rsp_valid | output | 1 | Response byte available |
| rsp_byte | output | 8 | Oldest queued response byte |
| rsp_ready | input | 1 | Host takes the response byte this cycle |
| trig_pos | input | 24 | Trigger position supplied by capture logic |
| stop_pos | input | 24 | Stop position supplied by capture logic |
| mode_o | output | 8 | Current mode register value |

## Verification
The address and the pending nibble are hidden, so a fault in either shows up only in a later read. It appears as the wrong byte, or as a correct byte at the wrong place in a burst, on the next response the host drains. That is usually one or two commands after the damaging byte. A queue fault shows up as a missing, duplicated or reordered response, or as `cmd_ready` staying high while a burst overruns the queue. A write landing in the wrong register changes `mode_o` on the very next cycle, or shows up the next time the scratch register is read.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;

  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;

  localparam logic [7:0] REG_ID       = 8'h00;
  localparam logic [7:0] REG_SCRATCH  = 8'h01;
  localparam logic [7:0] REG_MODE     = 8'h02;
  localparam logic [7:0] REG_POS_BASE = 8'h03;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_ADDR_LO,
    CMD_ADDR_HI,
    CMD_DATA_LO,
    CMD_DATA_WR,
    CMD_READ
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e        kind;
    logic             inc;
    logic [NIB_W-1:0] nib;
  } cmd_t;

  // Operation lives in the upper nibble; bit 7 marks post-read increment.
  function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
    cmd_t c;
    c.nib  = b[NIB_W-1:0];
    c.inc  = 1'b0;
    c.kind = CMD_NONE;
    unique case (b[7:4])
      4'h0:      c.kind = CMD_ADDR_LO;
      4'h1:      c.kind = CMD_ADDR_HI;
      4'h2:      c.kind = CMD_DATA_LO;
      4'h3:      c.kind = CMD_DATA_WR;
      4'h4,
      4'hC: begin
        c.kind = CMD_READ;
        c.inc  = b[7];
      end
      default:   c.kind = CMD_NONE;
    endcase
    return c;
  endfunction

  function automatic logic [BYTE_W-1:0] next_addr(input logic [BYTE_W-1:0] a);
    return a + 8'd1;
  endfunction

endpackage

// File: rtl/regcmd_parser.sv
module regcmd_parser
  import regcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [BYTE_W-1:0] cmd_byte,
  input  logic              accept_ok,
  output logic              wr_fire,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_fire,
  output logic              rd_inc,
  output logic [BYTE_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] addr_q
);

  cmd_t             cmd;
  logic             take;
  logic [NIB_W-1:0] lo_nib_q;

  assign cmd  = decode_cmd(cmd_byte);
  assign take = cmd_valid && accept_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      lo_nib_q <= '0;
    end else if (take) begin
      case (cmd.kind)
        CMD_ADDR_LO: addr_q[NIB_W-1:0]      <= cmd.nib;
        CMD_ADDR_HI: addr_q[BYTE_W-1:NIB_W] <= cmd.nib;
        CMD_DATA_LO: lo_nib_q               <= cmd.nib;
        CMD_READ:    if (cmd.inc) addr_q    <= next_addr(addr_q);
        default:     ;
      endcase
    end
  end

  assign wr_fire = take && (cmd.kind == CMD_DATA_WR);
  assign wr_addr = addr_q;
  assign wr_data = {cmd.nib, lo_nib_q};
  assign rd_fire = take && (cmd.kind == CMD_READ);
  assign rd_inc  = rd_fire && cmd.inc;
  assign rd_addr = addr_q;

endmodule

// File: rtl/regcmd_regfile.sv
module regcmd_regfile
  import regcmd_pkg::*;
#(
  parameter int              POS_W    = 24,
  parameter logic [BYTE_W-1:0] ID_VALUE = 8'hA6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [BYTE_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [POS_W-1:0]  trig_pos,
  input  logic [POS_W-1:0]  stop_pos,
  output logic [BYTE_W-1:0] scratch_q,
  output logic [BYTE_W-1:0] mode_q
);

  localparam int POS_BYTES = (POS_W + BYTE_W - 1) / BYTE_W;
  localparam int POS_PAD   = POS_BYTES * BYTE_W;
  localparam int NPOS      = 2 * POS_BYTES;

  logic [POS_PAD-1:0] trig_pad;
  logic [POS_PAD-1:0] stop_pad;
  logic [BYTE_W-1:0]  pos_bytes [NPOS];

  assign trig_pad = POS_PAD'(trig_pos);
  assign stop_pad = POS_PAD'(stop_pos);

  // Trigger bytes first, then stop bytes, each least significant first.
  for (genvar i = 0; i < POS_BYTES; i++) begin : g_pos
    assign pos_bytes[i]             = trig_pad[BYTE_W*i +: BYTE_W];
    assign pos_bytes[POS_BYTES + i] = stop_pad[BYTE_W*i +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scratch_q <= '0;
      mode_q    <= '0;
    end else if (wr_fire) begin
      case (wr_addr)
        REG_SCRATCH: scratch_q <= wr_data;
        REG_MODE:    mode_q    <= wr_data;
        default:     ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      REG_ID:      rd_data = ID_VALUE;
      REG_SCRATCH: rd_data = scratch_q;
      REG_MODE:    rd_data = mode_q;
      default: begin
        for (int i = 0; i < NPOS; i++) begin
          if (rd_addr == BYTE_W'(int'(REG_POS_BASE) + i)) rd_data = pos_bytes[i];
        end
      end
    endcase
  end

endmodule

// File: rtl/regcmd_rsp_fifo.sv
module regcmd_rsp_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic          do_push;
  logic          do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign do_push   = push && in_ready;
  assign do_pop    = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/regcmd_decoder.sv
module regcmd_decoder
  import regcmd_pkg::*;
#(
  parameter int                RSP_DEPTH = 4,
  parameter int                POS_W     = 24,
  parameter logic [BYTE_W-1:0] ID_VALUE  = 8'hA6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [BYTE_W-1:0] cmd_byte,
  output logic              cmd_ready,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_byte,
  input  logic              rsp_ready,
  input  logic [POS_W-1:0]  trig_pos,
  input  logic [POS_W-1:0]  stop_pos,
  output logic [BYTE_W-1:0] mode_o
);

  localparam int CW = $clog2(RSP_DEPTH + 1);

  logic              wr_fire;
  logic [BYTE_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data;
  logic              rd_fire;
  logic              rd_inc;
  logic [BYTE_W-1:0] rd_addr;
  logic [BYTE_W-1:0] rd_data;
  logic [BYTE_W-1:0] addr_q;
  logic [BYTE_W-1:0] scratch_q;
  logic [CW-1:0]     rsp_count;

  regcmd_parser u_parser (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .accept_ok (cmd_ready),
    .wr_fire   (wr_fire),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_fire   (rd_fire),
    .rd_inc    (rd_inc),
    .rd_addr   (rd_addr),
    .addr_q    (addr_q)
  );

  regcmd_regfile #(
    .POS_W    (POS_W),
    .ID_VALUE (ID_VALUE)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_fire   (wr_fire),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .trig_pos  (trig_pos),
    .stop_pos  (stop_pos),
    .scratch_q (scratch_q),
    .mode_q    (mode_o)
  );

  regcmd_rsp_fifo #(
    .DEPTH (RSP_DEPTH),
    .W     (BYTE_W)
  ) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rd_fire),
    .push_data (rd_data),
    .in_ready  (cmd_ready),
    .out_valid (rsp_valid),
    .out_data  (rsp_byte),
    .out_ready (rsp_ready),
    .count     (rsp_count)
  );

endmodule

// File: rtl/regcmd_decoder_chk.sv
module regcmd_decoder_chk #(
  parameter int          RSP_DEPTH = 4,
  parameter logic [7:0]  ID_VALUE  = 8'hA6,
  localparam int         CW        = $clog2(RSP_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [7:0]    rsp_byte,
  input logic          rd_fire,
  input logic          rd_inc,
  input logic [7:0]    rd_addr,
  input logic [7:0]    rd_data,
  input logic          wr_fire,
  input logic [7:0]    wr_addr,
  input logic [7:0]    wr_data,
  input logic [7:0]    addr_q,
  input logic [7:0]    scratch_q,
  input logic [CW-1:0] rsp_count
);

  assert_id_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && rd_addr == 8'h00) |-> (rd_data == ID_VALUE));

  assert_scratch_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_addr == 8'h01) |=> (scratch_q == $past(wr_data)));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && rd_inc) |=> (addr_q == $past(addr_q) + 8'd1));

  assert_addr_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !rd_inc) |=> $stable(addr_q));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_count <= CW'(RSP_DEPTH));

  assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |-> (!rd_fire && !wr_fire && rsp_valid));

  assert_read_queued_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid);

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_byte)));

endmodule

bind regcmd_decoder regcmd_decoder_chk #(
  .RSP_DEPTH (RSP_DEPTH),
  .ID_VALUE  (ID_VALUE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_byte  (rsp_byte),
  .rd_fire   (rd_fire),
  .rd_inc    (rd_inc),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .wr_fire   (wr_fire),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .addr_q    (addr_q),
  .scratch_q (scratch_q),
  .rsp_count (rsp_count)
);

// File: tb/regcmd_decoder_test.sv
`timescale 1ns/1ps
module regcmd_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_byte = 8'h00;
  logic        cmd_ready;
  logic        rsp_valid;
  logic [7:0]  rsp_byte;
  logic        rsp_ready = 1'b0;
  logic [23:0] trig_pos = 24'h123456;
  logic [23:0] stop_pos = 24'hABCDEF;
  logic [7:0]  mode_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  regcmd_decoder uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_byte  (rsp_byte),
    .rsp_ready (rsp_ready),
    .trig_pos  (trig_pos),
    .stop_pos  (stop_pos),
    .mode_o    (mode_o)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = b;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic set_addr(input logic [7:0] a);
    send({4'h0, a[3:0]});
    send({4'h1, a[7:4]});
  endtask

  task automatic write_byte(input logic [7:0] d);
    send({4'h2, d[3:0]});
    send({4'h3, d[7:4]});
  endtask

  task automatic expect_rsp(input logic [7:0] exp, input string req);
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
    check(rsp_byte == exp, req, rsp_byte, exp);
    rsp_ready = 1'b1;
    @(posedge clk);
    #1 rsp_ready = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
    check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    check(mode_o == 8'h00, "R1 mode_o", mode_o, 0);
    send(8'h40);
    expect_rsp(8'hA6, "R1 address 0 after reset");
  endtask

  task automatic t_id;
    set_addr(8'h00);
    write_byte(8'h55);
    send(8'h47);
    expect_rsp(8'hA6, "R6 id ignores write");
  endtask

  task automatic t_scratch;
    set_addr(8'h01);
    write_byte(8'h55);
    send(8'h40);
    expect_rsp(8'h55, "R7 scratch 0x55");
    write_byte(8'hAA);
    send(8'h40);
    expect_rsp(8'hAA, "R7 scratch 0xAA");
    write_byte(8'h12);
    write_byte(8'h34);
    send(8'h40);
    expect_rsp(8'h34, "R3 last pair wins");
    send(8'h40);
    expect_rsp(8'h34, "R4 read keeps address");
    write_byte(8'hAA);
  endtask

  task automatic t_mode;
    set_addr(8'h02);
    write_byte(8'h5A);
    check(mode_o == 8'h5A, "R8 mode_o after write", mode_o, 8'h5A);
    send(8'h40);
    expect_rsp(8'h5A, "R8 mode read");
  endtask

  task automatic t_addr_nibbles;
    set_addr(8'h13);
    send(8'h40);
    expect_rsp(8'h00, "R9 unmapped 0x13");
    send(8'h02);
    send(8'h40);
    expect_rsp(8'h00, "R2 low nibble keeps high (0x12)");
    send(8'h10);
    send(8'h40);
    expect_rsp(8'h5A, "R2 high nibble keeps low (0x02)");
  endtask

  task automatic t_burst;
    logic [7:0] exp [7];
    exp[0] = 8'h56; exp[1] = 8'h34; exp[2] = 8'h12;
    exp[3] = 8'hEF; exp[4] = 8'hCD; exp[5] = 8'hAB; exp[6] = 8'h00;
    set_addr(8'h03);
    fork
      begin
        for (int i = 0; i < 6; i++) send(8'hC0);
        send(8'h40);
      end
      begin
        for (int i = 0; i < 7; i++) expect_rsp(exp[i], "R9 R5 burst order");
      end
    join
  endtask

  task automatic t_stall;
    set_addr(8'h03);
    for (int i = 0; i < 4; i++) send(8'hC0);
    @(negedge clk);
    check(cmd_ready == 1'b0, "R10 full stalls", cmd_ready, 0);
    fork
      send(8'hC0);
      begin
        repeat (3) @(negedge clk);
        check(cmd_ready == 1'b0, "R10 still stalled", cmd_ready, 0);
        expect_rsp(8'h56, "R10 order 0");
        expect_rsp(8'h34, "R10 order 1");
        expect_rsp(8'h12, "R10 order 2");
        expect_rsp(8'hEF, "R10 order 3");
        expect_rsp(8'hCD, "R10 order 4");
      end
    join
    @(negedge clk);
    check(rsp_valid == 1'b0, "R10 no extra response", rsp_valid, 0);
  endtask

  task automatic t_wrap;
    set_addr(8'hFF);
    send(8'hC0);
    expect_rsp(8'h00, "R5 read at 0xFF");
    send(8'h40);
    expect_rsp(8'hA6, "R5 wrap to 0x00");
  endtask

  task automatic t_readonly;
    set_addr(8'h03);
    write_byte(8'h99);
    send(8'h40);
    expect_rsp(8'h56, "R9 position read-only");
    set_addr(8'h20);
    write_byte(8'h77);
    send(8'h40);
    expect_rsp(8'h00, "R9 unmapped write ignored");
  endtask

  task automatic t_ignored;
    set_addr(8'h01);
    send(8'h27);
    send(8'h57);
    send(8'h6F);
    send(8'h8E);
    send(8'hBF);
    send(8'hD0);
    send(8'hE1);
    send(8'hF2);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11 no response", rsp_valid, 0);
    check(mode_o == 8'h5A, "R11 mode untouched", mode_o, 8'h5A);
    send(8'h40);
    expect_rsp(8'hAA, "R11 address and scratch kept");
    send(8'h3C);
    send(8'h40);
    expect_rsp(8'hC7, "R11 pending nibble kept");
  endtask

  task automatic t_hold;
    set_addr(8'h02);
    send(8'h40);
    @(negedge clk);
    check(rsp_valid && rsp_byte == 8'h5A, "R12 first look", rsp_byte, 8'h5A);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(rsp_valid && rsp_byte == 8'h5A, "R12 held", rsp_byte, 8'h5A);
    end
    expect_rsp(8'h5A, "R12 drained");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_id();
    t_scratch();
    t_mode();
    t_addr_nibbles();
    t_burst();
    t_stall();
    t_wrap();
    t_readonly();
    t_ignored();
    t_hold();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule